// File: doc/BRIEF.md
# TLB Miss Assist-Register Loader

When an address translation misses in the TLB, software needs a prepared set of assist registers before it can build and install a replacement entry. This block fills those registers. One cycle after a miss strobe, all six registers update together.

The values come from several places:
- the page number of the missed access;
- whether the access was an instruction fetch or a data access;
- the machine-state address-space bits;
- an optional external-PID context, which tags a data access with another address space and process ID;
- the fields of a default-value register;
- three process-ID registers.

A round-robin victim pointer supplies the entry-select field and then moves to the next way. Between misses the registers hold their contents. The lookup itself and the TLB write path lie outside this block.

Top module: `tmas_loader`

## Requirements
- R1: After reset every assist register (`asr_sel`, `asr_tag`, `asr_epn`, `asr_rpn`, `asr_srch`, `asr_rpnhi`) reads zero and `upd_vld` is low. The victim pointer restarts at way 0.
- R2: A cycle with `miss_vld` high loads all six registers at that clock edge. `upd_vld` is high for exactly the following cycle.
- R3: The default-register fields are copied as follows: `dflt_tlbsel` to `asr_sel[29:28]`, `dflt_tsize` to `asr_tag[11:7]`, and `dflt_wimge` to `asr_epn[4:0]`.
- R4: On a miss, `asr_tag[31]` (valid) is set and `asr_epn[31:12]` receives `miss_vpn`. `asr_rpn` and `asr_rpnhi` are cleared, and all unassigned bits read zero.
- R5: The miss address space is chosen as follows: `ms_is` for a fetch (`miss_fetch`=1); `ext_as` for a data access with `ext_tag`=1; `ms_ds` for any other data access. When it is 1, both `asr_tag[12]` and `asr_srch[0]` are set.
- R6: For an untagged access, `dflt_tidsel` picks the missed TID placed in `asr_tag[29:16]`: 0 picks `pid0`, 1 picks `pid1`, 2 picks `pid2`, and 3 gives zero. `asr_srch[29:16]` receives `pid0`.
- R7: For a tagged access (`ext_tag`=1, fetch or data), `ext_pid`, zero-extended, goes to both `asr_tag[29:16]` and `asr_srch[29:16]`.
- R8: `asr_sel[17:16]` receives the victim pointer, which then advances by one modulo `NWAYS` (default 4) after each miss load.
- R9: In cycles with `miss_vld` low, all assist registers keep their values and `upd_vld` is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_vld | input | 1 | Miss strobe, one cycle per miss |
| miss_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| miss_vpn | input | 20 | Effective page number of the missed address |
| ms_is | input | 1 | Machine-state instruction address space |
| ms_ds | input | 1 | Machine-state data address space |
| ext_tag | input | 1 | Access uses the external-PID context |
| ext_as | input | 1 | External-context address space |
| ext_pid | input | 8 | External-context process ID |
| dflt_tlbsel | input | 2 | Default TLB array select |
| dflt_tsize | input | 5 | Default page size |
| dflt_wimge | input | 5 | Default storage attributes |
| dflt_tidsel | input | 2 | Default TID source selector |
| pid0 | input | 14 | Primary process ID |
| pid1 | input | 14 | Second process ID |
| pid2 | input | 14 | Third process ID |
| upd_vld | output | 1 | Registers were loaded at the last edge |
| asr_sel | output | 32 | Array/entry select register |
| asr_tag | output | 32 | Valid, TID, address space, size |
| asr_epn | output | 32 | Page number and attributes |
| asr_rpn | output | 32 | Real page low part (cleared) |
| asr_srch | output | 32 | Search PID and search space |
| asr_rpnhi | output | 32 | Real page high part (cleared) |

## Verification
The bench targets the following corner cases:

- **Selector value 3.** A design that forwards some PID on this value would show a nonzero TID.
- **Tagged fetch.** Here the instruction space must still win over `ext_as`. A design that lets the external context steer the fetch space would flip `asr_tag[12]`.
- **Search PID on tagged misses.** A design that keeps `pid0` in the search PID would show a stale search PID.
- **Back-to-back misses past the way count.** These expose a victim pointer that skips, sticks or fails to wrap.
- **Idle stretches and a mid-run reset.** These catch registers that drift between misses and a pointer that survives reset.

// File: rtl/tmas_pkg.sv
package tmas_pkg;
  localparam int REG_W      = 32;
  localparam int VALID_BIT  = 31;
  localparam int TID_LSB    = 16;
  localparam int TS_BIT     = 12;
  localparam int TSIZE_LSB  = 7;
  localparam int TSIZE_W    = 5;
  localparam int WIMGE_W    = 5;
  localparam int TLBSEL_LSB = 28;
  localparam int TLBSEL_W   = 2;
  localparam int ESEL_LSB   = 16;
  localparam int SPID_LSB   = 16;
  localparam int SAS_BIT    = 0;

  typedef enum logic [1:0] {
    TSEL_PID0 = 2'd0,
    TSEL_PID1 = 2'd1,
    TSEL_PID2 = 2'd2,
    TSEL_NONE = 2'd3
  } tid_sel_e;
endpackage

// File: rtl/tmas_tid_pick.sv
module tmas_tid_pick
  import tmas_pkg::*;
#(
  parameter int TIDW = 14,
  parameter int EPW  = 8
) (
  input  logic            ext_tag,
  input  logic [1:0]      tidsel,
  input  logic [TIDW-1:0] pid0,
  input  logic [TIDW-1:0] pid1,
  input  logic [TIDW-1:0] pid2,
  input  logic [EPW-1:0]  ext_pid,
  output logic [TIDW-1:0] miss_tid,
  output logic [TIDW-1:0] srch_pid
);
  localparam int PADW = TIDW - EPW;

  logic [TIDW-1:0] ext_wide;
  logic [TIDW-1:0] dflt_tid;

  assign ext_wide = {{PADW{1'b0}}, ext_pid};

  always_comb begin
    case (tid_sel_e'(tidsel))
      TSEL_PID0: dflt_tid = pid0;
      TSEL_PID1: dflt_tid = pid1;
      TSEL_PID2: dflt_tid = pid2;
      default:   dflt_tid = '0;
    endcase
  end

  assign miss_tid = ext_tag ? ext_wide : dflt_tid;
  assign srch_pid = ext_tag ? ext_wide : pid0;
endmodule

// File: rtl/tmas_victim_ptr.sv
module tmas_victim_ptr #(
  parameter int NWAYS = 4,
  localparam int WAYW = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [WAYW-1:0] way
);
  logic [WAYW-1:0] way_q;
  logic [WAYW-1:0] way_nxt;

  generate
    if ((NWAYS & (NWAYS - 1)) == 0) begin : g_pow2
      always_comb way_nxt = way_q + 1'b1;
    end else begin : g_wrap
      localparam logic [WAYW-1:0] LAST = WAYW'(NWAYS - 1);
      always_comb way_nxt = (way_q == LAST) ? '0 : way_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   way_q <= '0;
    else if (adv) way_q <= way_nxt;
  end

  assign way = way_q;
endmodule

// File: rtl/tmas_pack.sv
module tmas_pack
  import tmas_pkg::*;
#(
  parameter int VPNW = 20,
  parameter int PGSH = 12,
  parameter int TIDW = 14,
  parameter int WAYW = 2
) (
  input  logic                 miss_fetch,
  input  logic [VPNW-1:0]      miss_vpn,
  input  logic                 ms_is,
  input  logic                 ms_ds,
  input  logic                 ext_tag,
  input  logic                 ext_as,
  input  logic [TLBSEL_W-1:0]  dflt_tlbsel,
  input  logic [TSIZE_W-1:0]   dflt_tsize,
  input  logic [WIMGE_W-1:0]   dflt_wimge,
  input  logic [TIDW-1:0]      miss_tid,
  input  logic [TIDW-1:0]      srch_pid,
  input  logic [WAYW-1:0]      way,
  output logic [REG_W-1:0]     nxt_sel,
  output logic [REG_W-1:0]     nxt_tag,
  output logic [REG_W-1:0]     nxt_epn,
  output logic [REG_W-1:0]     nxt_srch
);
  logic space;

  always_comb begin
    if (miss_fetch)   space = ms_is;
    else if (ext_tag) space = ext_as;
    else              space = ms_ds;
  end

  always_comb begin
    nxt_sel  = '0;
    nxt_tag  = '0;
    nxt_epn  = '0;
    nxt_srch = '0;
    nxt_sel[TLBSEL_LSB +: TLBSEL_W] = dflt_tlbsel;
    nxt_sel[ESEL_LSB +: WAYW]       = way;
    nxt_tag[VALID_BIT]              = 1'b1;
    nxt_tag[TID_LSB +: TIDW]        = miss_tid;
    nxt_tag[TS_BIT]                 = space;
    nxt_tag[TSIZE_LSB +: TSIZE_W]   = dflt_tsize;
    nxt_epn[PGSH +: VPNW]           = miss_vpn;
    nxt_epn[0 +: WIMGE_W]           = dflt_wimge;
    nxt_srch[SPID_LSB +: TIDW]      = srch_pid;
    nxt_srch[SAS_BIT]               = space;
  end
endmodule

// File: rtl/tmas_loader.sv
module tmas_loader
  import tmas_pkg::*;
#(
  parameter int VPNW  = 20,
  parameter int PGSH  = 12,
  parameter int TIDW  = 14,
  parameter int EPW   = 8,
  parameter int NWAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_vld,
  input  logic             miss_fetch,
  input  logic [VPNW-1:0]  miss_vpn,
  input  logic             ms_is,
  input  logic             ms_ds,
  input  logic             ext_tag,
  input  logic             ext_as,
  input  logic [EPW-1:0]   ext_pid,
  input  logic [1:0]       dflt_tlbsel,
  input  logic [4:0]       dflt_tsize,
  input  logic [4:0]       dflt_wimge,
  input  logic [1:0]       dflt_tidsel,
  input  logic [TIDW-1:0]  pid0,
  input  logic [TIDW-1:0]  pid1,
  input  logic [TIDW-1:0]  pid2,
  output logic             upd_vld,
  output logic [31:0]      asr_sel,
  output logic [31:0]      asr_tag,
  output logic [31:0]      asr_epn,
  output logic [31:0]      asr_rpn,
  output logic [31:0]      asr_srch,
  output logic [31:0]      asr_rpnhi
);
  localparam int WAYW = (NWAYS > 1) ? $clog2(NWAYS) : 1;

  logic [TIDW-1:0]  miss_tid, srch_pid;
  logic [WAYW-1:0]  way;
  logic [REG_W-1:0] nxt_sel, nxt_tag, nxt_epn, nxt_srch;
  logic [REG_W-1:0] sel_q, tag_q, epn_q, rpn_q, srch_q, rpnhi_q;
  logic             upd_q;

  tmas_tid_pick #(.TIDW(TIDW), .EPW(EPW)) tid_i (
    .ext_tag(ext_tag), .tidsel(dflt_tidsel),
    .pid0(pid0), .pid1(pid1), .pid2(pid2), .ext_pid(ext_pid),
    .miss_tid(miss_tid), .srch_pid(srch_pid)
  );

  tmas_victim_ptr #(.NWAYS(NWAYS)) vic_i (
    .clk(clk), .rst_n(rst_n), .adv(miss_vld), .way(way)
  );

  tmas_pack #(.VPNW(VPNW), .PGSH(PGSH), .TIDW(TIDW), .WAYW(WAYW)) pack_i (
    .miss_fetch(miss_fetch), .miss_vpn(miss_vpn), .ms_is(ms_is), .ms_ds(ms_ds),
    .ext_tag(ext_tag), .ext_as(ext_as), .dflt_tlbsel(dflt_tlbsel),
    .dflt_tsize(dflt_tsize), .dflt_wimge(dflt_wimge), .miss_tid(miss_tid),
    .srch_pid(srch_pid), .way(way), .nxt_sel(nxt_sel), .nxt_tag(nxt_tag),
    .nxt_epn(nxt_epn), .nxt_srch(nxt_srch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= miss_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      tag_q   <= '0;
      epn_q   <= '0;
      rpn_q   <= '0;
      srch_q  <= '0;
      rpnhi_q <= '0;
    end else if (miss_vld) begin
      sel_q   <= nxt_sel;
      tag_q   <= nxt_tag;
      epn_q   <= nxt_epn;
      rpn_q   <= '0;
      srch_q  <= nxt_srch;
      rpnhi_q <= '0;
    end
  end

  assign upd_vld   = upd_q;
  assign asr_sel   = sel_q;
  assign asr_tag   = tag_q;
  assign asr_epn   = epn_q;
  assign asr_rpn   = rpn_q;
  assign asr_srch  = srch_q;
  assign asr_rpnhi = rpnhi_q;
endmodule

// File: rtl/tmas_loader_chk.sv
module tmas_loader_chk #(
  parameter int TIDW  = 14,
  parameter int EPW   = 8,
  parameter int NWAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_vld,
  input logic            ext_tag,
  input logic [EPW-1:0]  ext_pid,
  input logic [1:0]      dflt_tidsel,
  input logic            upd_vld,
  input logic [31:0]     asr_sel,
  input logic [31:0]     asr_tag,
  input logic [31:0]     asr_epn,
  input logic [31:0]     asr_rpn,
  input logic [31:0]     asr_srch,
  input logic [31:0]     asr_rpnhi
);
  localparam int WAYW = (NWAYS > 1) ? $clog2(NWAYS) : 1;
  localparam logic [WAYW-1:0] LAST = WAYW'(NWAYS - 1);

  logic [WAYW-1:0] esel_now, esel_step;
  logic [TIDW-1:0] ext_wide;

  assign esel_now  = asr_sel[16 +: WAYW];
  assign esel_step = (esel_now == LAST) ? '0 : esel_now + 1'b1;
  assign ext_wide  = TIDW'(ext_pid);

  assert_upd_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> upd_vld);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_vld |=> !upd_vld && $stable(asr_sel) && $stable(asr_tag) &&
    $stable(asr_epn) && $stable(asr_srch) && $stable(asr_rpn) && $stable(asr_rpnhi));

  assert_valid_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> asr_tag[31] && asr_rpn == '0 && asr_rpnhi == '0);

  assert_space_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> asr_tag[12] == asr_srch[0]);

  assert_none_tid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && !ext_tag && dflt_tidsel == 2'd3) |=> asr_tag[16 +: TIDW] == '0);

  assert_ext_tid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && ext_tag) |=> asr_tag[16 +: TIDW] == $past(ext_wide) &&
    asr_srch[16 +: TIDW] == $past(ext_wide));

  assert_victim_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && miss_vld) |=> esel_now == $past(esel_step));

  wire unused_ok = ^asr_epn;
endmodule

bind tmas_loader tmas_loader_chk #(.TIDW(TIDW), .EPW(EPW), .NWAYS(NWAYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .ext_tag(ext_tag),
  .ext_pid(ext_pid), .dflt_tidsel(dflt_tidsel), .upd_vld(upd_vld),
  .asr_sel(asr_sel), .asr_tag(asr_tag), .asr_epn(asr_epn), .asr_rpn(asr_rpn),
  .asr_srch(asr_srch), .asr_rpnhi(asr_rpnhi)
);

// File: tb/tmas_loader_tb_top.sv
`timescale 1ns/1ps
module tmas_loader_tb_top;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic miss_vld, miss_fetch, ms_is, ms_ds, ext_tag, ext_as;
  logic [19:0] miss_vpn;
  logic [7:0]  ext_pid;
  logic [1:0]  dflt_tlbsel, dflt_tidsel;
  logic [4:0]  dflt_tsize, dflt_wimge;
  logic [13:0] pid0, pid1, pid2;
  logic        upd_vld;
  logic [31:0] asr_sel, asr_tag, asr_epn, asr_rpn, asr_srch, asr_rpnhi;

  always #4 clk = ~clk;

  tmas_loader dut_i (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_fetch(miss_fetch),
    .miss_vpn(miss_vpn), .ms_is(ms_is), .ms_ds(ms_ds), .ext_tag(ext_tag),
    .ext_as(ext_as), .ext_pid(ext_pid), .dflt_tlbsel(dflt_tlbsel),
    .dflt_tsize(dflt_tsize), .dflt_wimge(dflt_wimge), .dflt_tidsel(dflt_tidsel),
    .pid0(pid0), .pid1(pid1), .pid2(pid2), .upd_vld(upd_vld),
    .asr_sel(asr_sel), .asr_tag(asr_tag), .asr_epn(asr_epn), .asr_rpn(asr_rpn),
    .asr_srch(asr_srch), .asr_rpnhi(asr_rpnhi)
  );

  typedef struct packed {
    logic [31:0] sel, tag, epn, srch;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_chk = 0;
  int   n_bad = 0;
  int   ptr_m = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    logic sp;
    logic [13:0] tid;
    sp = miss_fetch ? ms_is : (ext_tag ? ext_as : ms_ds);
    if (ext_tag) tid = {6'd0, ext_pid};
    else case (dflt_tidsel)
      2'd0: tid = pid0;
      2'd1: tid = pid1;
      2'd2: tid = pid2;
      default: tid = 14'd0;
    endcase
    e.sel  = ({30'd0, dflt_tlbsel} << 28) | (32'(ptr_m) << 16);
    e.tag  = (32'd1 << 31) | ({18'd0, tid} << 16) | ({31'd0, sp} << 12) | ({27'd0, dflt_tsize} << 7);
    e.epn  = ({12'd0, miss_vpn} << 12) | {27'd0, dflt_wimge};
    e.srch = ({18'd0, (ext_tag ? {6'd0, ext_pid} : pid0)} << 16) | {31'd0, sp};
    return e;
  endfunction

  // Driver: called at a negedge; leaves miss_vld high for one edge.
  task automatic fire();
    exp_t e;
    e = model();
    exp_q.push_back(e);
    last_exp = e;
    ptr_m = (ptr_m + 1) % NW;
    miss_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    miss_vld = 1'b0;
    repeat (n) @(negedge clk);
    check("R9 upd_vld idle", {31'd0, upd_vld}, 32'd0);
    check("R9 sel hold", asr_sel, last_exp.sel);
    check("R9 tag hold", asr_tag, last_exp.tag);
    check("R9 srch hold", asr_srch, last_exp.srch);
  endtask

  task automatic set_vec(input logic f, input logic [19:0] v, input logic is_, input logic ds_,
                         input logic tg, input logic eas, input logic [7:0] ep,
                         input logic [1:0] ts, input logic [1:0] tl);
    miss_fetch = f; miss_vpn = v; ms_is = is_; ms_ds = ds_;
    ext_tag = tg; ext_as = eas; ext_pid = ep; dflt_tidsel = ts; dflt_tlbsel = tl;
  endtask

  task automatic rand_vec();
    miss_fetch = 1'($urandom); miss_vpn = 20'($urandom); ms_is = 1'($urandom);
    ms_ds = 1'($urandom); ext_tag = 1'($urandom); ext_as = 1'($urandom);
    ext_pid = 8'($urandom); dflt_tidsel = 2'($urandom); dflt_tlbsel = 2'($urandom);
    dflt_tsize = 5'($urandom); dflt_wimge = 5'($urandom);
    pid0 = 14'($urandom); pid1 = 14'($urandom); pid2 = 14'($urandom);
  endtask

  task automatic do_reset();
    miss_vld = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.delete();
    ptr_m = 0;
    check("R1 upd_vld reset", {31'd0, upd_vld}, 32'd0);
    check("R1 sel reset", asr_sel, 32'd0);
    check("R1 tag reset", asr_tag, 32'd0);
    check("R1 epn reset", asr_epn, 32'd0);
    check("R1 rpn reset", asr_rpn, 32'd0);
    check("R1 srch reset", asr_srch, 32'd0);
    check("R1 rpnhi reset", asr_rpnhi, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    last_exp = '0;
  endtask

  // Monitor: pops an expected item whenever an update is reported.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && upd_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected upd_vld", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R3/R8 sel", asr_sel, e.sel);
        check("R4/R5/R6/R7 tag", asr_tag, e.tag);
        check("R3/R4 epn", asr_epn, e.epn);
        check("R4 rpn clear", asr_rpn, 32'd0);
        check("R4 rpnhi clear", asr_rpnhi, 32'd0);
        check("R5/R6/R7 srch", asr_srch, e.srch);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    set_vec(0, 20'h0, 0, 0, 0, 0, 8'h0, 2'd0, 2'd0);
    dflt_tsize = 5'd0; dflt_wimge = 5'd0; pid0 = '0; pid1 = '0; pid2 = '0;
    miss_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    pid0 = 14'h1234; pid1 = 14'h2ABC; pid2 = 14'h3F01;
    dflt_tsize = 5'h13; dflt_wimge = 5'h0A;
    // R6: each selector value, untagged data, ms_ds drives space (R5)
    set_vec(0, 20'hABCDE, 0, 1, 0, 0, 8'h55, 2'd0, 2'd1); fire(); idle(2);
    set_vec(0, 20'h00001, 1, 0, 0, 1, 8'h55, 2'd1, 2'd2); fire(); idle(2);
    set_vec(0, 20'hFFFFF, 0, 1, 0, 0, 8'h55, 2'd2, 2'd3); fire(); idle(2);
    set_vec(0, 20'h12345, 0, 0, 0, 1, 8'h55, 2'd3, 2'd0); fire(); idle(2);
    // R5: fetch uses ms_is even when tagged and ext_as differs
    set_vec(1, 20'h0F0F0, 1, 0, 1, 0, 8'hC3, 2'd1, 2'd1); fire(); idle(2);
    set_vec(1, 20'h0F0F1, 0, 1, 0, 1, 8'hC3, 2'd2, 2'd1); fire(); idle(2);
    // R7: tagged data uses ext_as and ext_pid for TID and search PID
    set_vec(0, 20'h54321, 0, 0, 1, 1, 8'hFF, 2'd2, 2'd2); fire(); idle(2);
    set_vec(0, 20'h54322, 1, 1, 1, 0, 8'h01, 2'd3, 2'd2); fire(); idle(3);
    // R8: back-to-back misses wrap the victim pointer
    for (int k = 0; k < 6; k++) begin
      set_vec(0, 20'(k * 7), 0, k[0], k[1], k[0], 8'(k), 2'(k), 2'(k)); fire();
    end
    idle(2);
    // R1: reset mid-run restarts victim pointer at way 0
    do_reset();
    set_vec(0, 20'h77777, 0, 1, 0, 0, 8'h10, 2'd0, 2'd1); fire(); idle(2);
    // Mixed random traffic, including back-to-back misses
    for (int k = 0; k < 60; k++) begin
      rand_vec();
      fire();
      if ($urandom_range(0, 2) == 0) idle(1 + $urandom_range(0, 2));
    end
    idle(3);
    check("R2 all expected updates seen", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule